// File: doc/BRIEF.md
# Prioritized Multi-Source Interrupt Controller

This block gathers interrupt requests from eighteen peripheral sources on behalf of a small 8-bit processor core and decides which one, if any, the core should service next. Each source owns a handful of raw event lines. Every line passes through its own sub-mask bit, and the surviving lines merge into one request flag per source. Port-style sources keep their flag equal to the merged event level. All other sources capture a rising edge into a sticky flag. Pending flags are then gated by per-source enables and one global enable.

Sources are gathered into six groups, and each group carries a 2-bit priority level that software writes. The pending source with the highest level wins, and the lowest source index breaks a tie. The winner is shown to the core as a request together with a vector address of eight times the index plus three. When the core acknowledges, the winner's level is recorded as in service. Most edge-captured flags also clear at that point. A return strobe retires the most recent level. While a level is in service, only a strictly higher level can raise a new request.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all flags read 0, nothing is in service, all enables and group levels are 0 and `irqReq` is 0.
- R2: Event line j of source n is bit 4n+j of `evtIn`, and it passes only when the same bit of `subMask` is 1. For a source with index 3 or more, the flag sets one cycle after the OR of its passed lines rises, and it stays set until it is cleared. A line held high does not set the flag again after a clear.
- R3: For sources 0, 1 and 2, the flag equals the OR of the passed lines one cycle earlier. `flagClr` and acknowledge do not change it.
- R4: A source can request only when its flag is 1, its enable bit is 1 and the global enable is 1. Register writes use `regAddr`. Address 0 holds the global enable in bit 7 and sources 0..5 in bits 5:0. Address 1 holds sources 6..11 in bits 5:0. Address 2 holds sources 12..17 in bits 5:0.
- R5: Source n belongs to group n mod 6. Address 3 holds the levels of groups 0..3 in bits [2g+1:2g]. Address 4 holds groups 4 and 5 in bits 1:0 and 3:2. The highest level wins, and among equal levels the lowest index wins.
- R6: While `irqReq` is 1, `vecAddr` equals 8n+3 for the winning source n.
- R7: `ackStb` together with `irqReq` marks the winner's level as in service. While any level is in service, `irqReq` is 1 only if the winner's level is strictly above the highest level in service.
- R8: `retStb` removes the highest level in service.
- R9: On acknowledge, the winning flag is cleared the next cycle for sources 3..14. Flags of sources 15..17 stay set until `flagClr` clears them.
- R10: When a rising edge and a `flagClr` bit reach the same edge-captured flag in the same cycle, the flag ends up set.
- R11: `ackStb` while `irqReq` is 0 is ignored and leaves the in-service state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 72 | Raw event lines, four per source |
| subMask | input | 72 | Per-line pass bits (1 = pass) |
| flagClr | input | 18 | Software flag clear strobes, one per source |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address 0..4 (5..7 ignored) |
| regWrData | input | 8 | Register write data |
| ackStb | input | 1 | Core acknowledges the presented vector |
| retStb | input | 1 | Core returns from a service routine |
| irqReq | output | 1 | Interrupt request to the core |
| vecAddr | output | 8 | Vector address of the winning source |
| flags | output | 18 | Current request flags |

## Verification
Directed sequences separate the two flag styles. A held level line is cleared in software and then acknowledged, which shows that a level flag ignores both while an edge flag re-arms only on a new rise. Priority is tried with pairs of pending sources whose group levels are swapped, made equal and then raised. This distinguishes level-first selection from index-first selection. Nesting is driven through two acknowledges and two returns with a low-level request kept pending, so a wrong stack order or a non-strict comparison shows up as a wrong request. A seeded random phase then mixes sparse event toggles, sub-mask changes, clears, register writes, acknowledges and returns against a bench model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC  = 18;
  localparam int SUB_EVT  = 4;
  localparam int NUM_GRP  = 6;
  localparam int LVL_W    = 2;
  localparam int NUM_LVL  = 1 << LVL_W;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int VEC_W    = IDX_W + 3;
  localparam int EN_REGS  = 3;
  localparam int PR_REGS  = 2;

  typedef struct packed {
    logic               ackFire;
    logic [EN_REGS-1:0] wrEn;
    logic [PR_REGS-1:0] wrPr;
  } irqStb_t;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NUM_SRC-1:0]            cand,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] srcLvl,
  output logic                          valid,
  output logic [IDX_W-1:0]              bestIdx,
  output logic [LVL_W-1:0]              bestLvl
);
  // ascending scan with strict compare: highest level, then lowest index
  always_comb begin
    valid   = 1'b0;
    bestIdx = '0;
    bestLvl = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (cand[n] && (!valid || srcLvl[n] > bestLvl)) begin
        valid   = 1'b1;
        bestIdx = IDX_W'(n);
        bestLvl = srcLvl[n];
      end
    end
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter logic [NUM_SRC-1:0] LEVEL_MASK   = 18'h00007,
  parameter logic [NUM_SRC-1:0] AUTOCLR_MASK = 18'h07FF8
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC*SUB_EVT-1:0] evtIn,
  input  logic [NUM_SRC*SUB_EVT-1:0] subMask,
  input  logic [NUM_SRC-1:0]         flagClr,
  input  logic [7:0]                 regWrData,
  input  irqStb_t                    stb,
  output logic [NUM_SRC-1:0]         flags,
  output logic                       reqValid,
  output logic [LVL_W-1:0]           bestLvl,
  output logic [VEC_W-1:0]           vecAddr
);
  localparam int EN_PER_REG  = 6;
  localparam int GRP_PER_REG = 4;

  logic [NUM_SRC-1:0]            srcEn;
  logic                          globalEn;
  logic [NUM_GRP-1:0][LVL_W-1:0] grpLvl;
  logic [NUM_SRC-1:0]            cand;
  logic [NUM_SRC-1:0][LVL_W-1:0] srcLvl;
  logic [IDX_W-1:0]              bestIdx;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcEn    <= '0;
      globalEn <= 1'b0;
      grpLvl   <= '0;
    end else begin
      if (stb.wrEn[0]) globalEn <= regWrData[7];
      for (int n = 0; n < NUM_SRC; n++)
        if (stb.wrEn[n / EN_PER_REG]) srcEn[n] <= regWrData[n % EN_PER_REG];
      for (int g = 0; g < NUM_GRP; g++)
        if (stb.wrPr[g / GRP_PER_REG])
          grpLvl[g] <= regWrData[(g % GRP_PER_REG)*LVL_W +: LVL_W];
    end
  end

  // per-source flag cells
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    logic hit;
    logic fl;
    assign hit      = |(evtIn[n*SUB_EVT +: SUB_EVT] & subMask[n*SUB_EVT +: SUB_EVT]);
    assign flags[n] = fl;
    assign srcLvl[n] = grpLvl[n % NUM_GRP];

    if (LEVEL_MASK[n]) begin : g_level
      logic unusedClr;
      assign unusedClr = flagClr[n];
      always_ff @(posedge clk) begin
        if (!rstN) fl <= 1'b0;
        else       fl <= hit;
      end
    end else begin : g_edge
      logic prevHit;
      logic clrNow;
      assign clrNow = flagClr[n] |
                      (AUTOCLR_MASK[n] && stb.ackFire && bestIdx == IDX_W'(n));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          prevHit <= 1'b0;
          fl      <= 1'b0;
        end else begin
          prevHit <= hit;
          fl      <= (hit & ~prevHit) | (fl & ~clrNow);
        end
      end
    end
  end

  assign cand = flags & srcEn & {NUM_SRC{globalEn}};

  irq_arbiter u_arb (
    .cand    (cand),
    .srcLvl  (srcLvl),
    .valid   (reqValid),
    .bestIdx (bestIdx),
    .bestLvl (bestLvl)
  );

  assign vecAddr = {bestIdx, 3'b011};
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic               ackStb,
  input  logic               retStb,
  input  logic               reqValid,
  input  logic [LVL_W-1:0]   bestLvl,
  output irqStb_t            stb,
  output logic               irqReq,
  output logic [NUM_LVL-1:0] inService
);
  logic               busy;
  logic [LVL_W-1:0]   curLvl;
  logic [NUM_LVL-1:0] popVec;
  logic [NUM_LVL-1:0] pushVec;

  always_comb begin
    curLvl = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (inService[l]) curLvl = LVL_W'(l);
  end

  assign busy   = |inService;
  assign irqReq = reqValid && (!busy || bestLvl > curLvl);

  always_comb begin
    stb.ackFire = ackStb && irqReq;
    for (int i = 0; i < EN_REGS; i++)
      stb.wrEn[i] = regWrEn && (regAddr == 3'(i));
    for (int j = 0; j < PR_REGS; j++)
      stb.wrPr[j] = regWrEn && (regAddr == 3'(EN_REGS + j));
  end

  assign popVec  = (retStb && busy) ? (NUM_LVL'(1) << curLvl) : '0;
  assign pushVec = stb.ackFire ? (NUM_LVL'(1) << bestLvl) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) inService <= '0;
    else       inService <= (inService & ~popVec) | pushVec;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter logic [NUM_SRC-1:0] LEVEL_MASK   = 18'h00007,
  parameter logic [NUM_SRC-1:0] AUTOCLR_MASK = 18'h07FF8
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC*SUB_EVT-1:0] evtIn,
  input  logic [NUM_SRC*SUB_EVT-1:0] subMask,
  input  logic [NUM_SRC-1:0]         flagClr,
  input  logic                       regWrEn,
  input  logic [2:0]                 regAddr,
  input  logic [7:0]                 regWrData,
  input  logic                       ackStb,
  input  logic                       retStb,
  output logic                       irqReq,
  output logic [VEC_W-1:0]           vecAddr,
  output logic [NUM_SRC-1:0]         flags
);
  irqStb_t            stb;
  logic               reqValid;
  logic [LVL_W-1:0]   bestLvl;
  logic [NUM_LVL-1:0] inService;

  irq_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .ackStb    (ackStb),
    .retStb    (retStb),
    .reqValid  (reqValid),
    .bestLvl   (bestLvl),
    .stb       (stb),
    .irqReq    (irqReq),
    .inService (inService)
  );

  irq_datapath #(
    .LEVEL_MASK   (LEVEL_MASK),
    .AUTOCLR_MASK (AUTOCLR_MASK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .evtIn     (evtIn),
    .subMask   (subMask),
    .flagClr   (flagClr),
    .regWrData (regWrData),
    .stb       (stb),
    .flags     (flags),
    .reqValid  (reqValid),
    .bestLvl   (bestLvl),
    .vecAddr   (vecAddr)
  );
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               irqReq,
  input logic [VEC_W-1:0]   vecAddr,
  input logic [NUM_SRC-1:0] flags,
  input logic               ackStb,
  input logic               retStb,
  input logic [NUM_LVL-1:0] inService
);
  // R1: request low right after reset release
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> !irqReq);

  // R6: vector form and range
  a_r6_vec_form: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (vecAddr[2:0] == 3'd3 && int'(vecAddr[VEC_W-1:3]) < NUM_SRC));

  // R4: a request always points at a set flag
  a_r4_req_has_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> flags[vecAddr[VEC_W-1:3]]);

  // R7: acknowledge adds exactly one level
  a_r7_push_one: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && irqReq && !retStb) |=>
      $countones(inService) == $countones($past(inService)) + 1);

  // R8: return removes exactly one level
  a_r8_pop_one: assert property (@(posedge clk) disable iff (!rstN)
    (retStb && !(ackStb && irqReq) && inService != '0) |=>
      $countones(inService) + 1 == $countones($past(inService)));

  // R11: stray acknowledge leaves nesting state alone
  a_r11_idle_ack: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && !irqReq && !retStb) |=> $stable(inService));
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irqReq    (irqReq),
  .vecAddr   (vecAddr),
  .flags     (flags),
  .ackStb    (ackStb),
  .retStb    (retStb),
  .inService (u_ctl.inService)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int NS = 18;
  localparam int NE = 72;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NE-1:0] evtIn, subMask;
  logic [NS-1:0] flagClr;
  logic          regWrEn;
  logic [2:0]    regAddr;
  logic [7:0]    regWrData;
  logic          ackStb, retStb;
  logic          irqReq;
  logic [7:0]    vecAddr;
  logic [NS-1:0] flags;

  always #2 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .subMask(subMask), .flagClr(flagClr),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .ackStb(ackStb), .retStb(retStb), .irqReq(irqReq), .vecAddr(vecAddr), .flags(flags)
  );

  int nChk = 0, nBad = 0;
  bit done = 0;

  // model state
  logic [NS-1:0] mFlag, mPrev, mEn;
  logic          mGlb;
  int            mLvl [6];
  logic [3:0]    mIns;
  logic          eReq;
  int            eIdx, eLvl;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic mReset();
    mFlag = '0; mPrev = '0; mEn = '0; mGlb = 0; mIns = '0;
    for (int g = 0; g < 6; g++) mLvl[g] = 0;
  endtask

  task automatic resolve();
    bit v = 0; int bl = 0, bi = 0, cur = -1;
    for (int n = 0; n < NS; n++)
      if (mFlag[n] && mEn[n] && mGlb && (!v || mLvl[n % 6] > bl)) begin
        v = 1; bl = mLvl[n % 6]; bi = n;
      end
    for (int l = 0; l < 4; l++) if (mIns[l]) cur = l;
    eReq = v && (bl > cur);
    eIdx = bi; eLvl = bl;
  endtask

  task automatic cyc(string tag);
    logic [NS-1:0] hit;
    int cur;
    resolve();
    chk(flags === mFlag, {tag, " flags"}, flags, mFlag);
    chk(irqReq === eReq, {tag, " irqReq"}, irqReq, eReq);
    if (eReq) chk(vecAddr === 8'(8*eIdx+3), {tag, " vecAddr"}, vecAddr, 8*eIdx+3);
    @(posedge clk);
    if (!rstN) mReset();
    else begin
      for (int n = 0; n < NS; n++) hit[n] = |(evtIn[4*n +: 4] & subMask[4*n +: 4]);
      for (int n = 0; n < NS; n++) begin
        if (n < 3) mFlag[n] = hit[n];
        else begin
          bit clr = flagClr[n] || (ackStb && eReq && eIdx == n && n < 15);
          mFlag[n] = (hit[n] && !mPrev[n]) || (mFlag[n] && !clr);
        end
      end
      mPrev = hit;
      cur = -1;
      for (int l = 0; l < 4; l++) if (mIns[l]) cur = l;
      if (retStb && cur >= 0) mIns[cur] = 1'b0;
      if (ackStb && eReq) mIns[eLvl] = 1'b1;
      if (regWrEn) begin
        case (regAddr)
          3'd0: begin mGlb = regWrData[7]; mEn[5:0] = regWrData[5:0]; end
          3'd1: mEn[11:6] = regWrData[5:0];
          3'd2: mEn[17:12] = regWrData[5:0];
          3'd3: for (int g = 0; g < 4; g++) mLvl[g] = int'(regWrData[2*g +: 2]);
          3'd4: for (int g = 0; g < 2; g++) mLvl[4+g] = int'(regWrData[2*g +: 2]);
          default: ;
        endcase
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d, string tag);
    regWrEn = 1; regAddr = a; regWrData = d;
    cyc(tag);
    regWrEn = 0;
  endtask

  task automatic pulseAck(string tag);
    ackStb = 1; cyc(tag); ackStb = 0;
  endtask

  task automatic pulseRet(string tag);
    retStb = 1; cyc(tag); retStb = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed1234);
    rstN = 0; evtIn = '0; subMask = '1; flagClr = '0; regWrEn = 0;
    regAddr = '0; regWrData = '0; ackStb = 0; retStb = 0;
    mReset();
    @(negedge clk);
    repeat (3) cyc("R1");
    rstN = 1;
    cyc("R1");
    chk(irqReq == 0 && flags == '0, "R1 reset outputs", {irqReq, flags}, 0);

    wr(0, 8'hBF, "R4"); wr(1, 8'h3F, "R4"); wr(2, 8'h3F, "R4");
    wr(3, 8'h00, "R5"); wr(4, 8'h00, "R5");

    // R2: sub-mask blocks, then edge sets, held level does not re-set
    subMask[21] = 0; evtIn[21] = 1;
    cyc("R2"); cyc("R2");
    chk(flags[5] == 0, "R2 masked line", flags[5], 0);
    subMask[21] = 1; cyc("R2");
    chk(flags[5] == 1, "R2 edge set", flags[5], 1);
    flagClr[5] = 1; cyc("R2"); flagClr = '0; cyc("R2");
    chk(flags[5] == 0, "R2 no re-set on held level", flags[5], 0);
    evtIn[21] = 0; cyc("R2");

    // R3: level source ignores clear and acknowledge
    evtIn[4] = 1; cyc("R3");
    flagClr[1] = 1; cyc("R3"); flagClr = '0;
    chk(flags[1] == 1, "R3 clear ignored", flags[1], 1);
    pulseAck("R3");
    chk(flags[1] == 1, "R3 ack ignored", flags[1], 1);
    chk(irqReq == 0, "R7 same level blocked", irqReq, 0);
    pulseRet("R8");
    chk(irqReq == 1, "R8 return reopens", irqReq, 1);
    evtIn[4] = 0; cyc("R3"); cyc("R3");
    chk(flags[1] == 0, "R3 follows level", flags[1], 0);

    // R4: global and per-source enable
    evtIn[28] = 1; cyc("R4");
    wr(0, 8'h3F, "R4");
    chk(irqReq == 0, "R4 global off", irqReq, 0);
    wr(0, 8'hBF, "R4");
    chk(irqReq == 1, "R4 global on", irqReq, 1);
    chk(vecAddr == 8'd59, "R6 vector src7", vecAddr, 59);
    wr(1, 8'h3D, "R4");
    chk(irqReq == 0, "R4 source enable off", irqReq, 0);
    wr(1, 8'h3F, "R4");

    // R5: level first, then lowest index
    evtIn[16] = 1; cyc("R5");
    chk(vecAddr == 8'd35, "R5 tie lowest index", vecAddr, 35);
    wr(3, 8'h04, "R5");
    chk(vecAddr == 8'd59, "R5 higher level wins", vecAddr, 59);
    wr(4, 8'h01, "R5");
    chk(vecAddr == 8'd35, "R5 equal levels", vecAddr, 35);
    wr(4, 8'h00, "R5"); wr(3, 8'h08, "R5");
    chk(vecAddr == 8'd59, "R5 level two", vecAddr, 59);

    // R7: nesting
    pulseAck("R7");
    chk(irqReq == 0, "R7 lower pending blocked", irqReq, 0);
    chk(flags[7] == 0, "R9 auto clear", flags[7], 0);
    wr(3, 8'hC8, "R7");
    evtIn[36] = 1; cyc("R7");
    chk(irqReq == 1 && vecAddr == 8'd75, "R7 higher preempts", {irqReq, vecAddr}, {1'b1, 8'd75});
    pulseAck("R7");
    chk(irqReq == 0, "R7 after second ack", irqReq, 0);

    // R8: unwind
    pulseRet("R8");
    chk(irqReq == 0, "R8 one level left", irqReq, 0);
    pulseRet("R8");
    chk(irqReq == 1 && vecAddr == 8'd35, "R8 all unwound", {irqReq, vecAddr}, {1'b1, 8'd35});

    // R9: software-cleared source survives acknowledge
    pulseAck("R9"); pulseRet("R9");
    evtIn[64] = 1; cyc("R9");
    chk(vecAddr == 8'd131, "R6 vector src16", vecAddr, 131);
    pulseAck("R9");
    chk(flags[16] == 1, "R9 no auto clear", flags[16], 1);
    pulseRet("R9");
    flagClr[16] = 1; cyc("R9"); flagClr = '0;
    chk(flags[16] == 0, "R9 software clear", flags[16], 0);

    // R10: set beats clear
    evtIn[32] = 1; flagClr[8] = 1; cyc("R10"); flagClr = '0;
    chk(flags[8] == 1, "R10 set wins", flags[8], 1);

    // R11: stray acknowledge
    wr(0, 8'h3F, "R11");
    pulseAck("R11");
    wr(0, 8'hBF, "R11");
    chk(irqReq == 1, "R11 ack ignored", irqReq, 1);

    evtIn = '0; flagClr = '1; cyc("R2"); flagClr = '0;
    repeat (4) pulseRet("R8");

    // random phase
    for (int k = 0; k < 4000; k++) begin
      for (int b = 0; b < 3; b++) if ($urandom % 4 == 0) evtIn[$urandom % NE] ^= 1'b1;
      if ($urandom % 8 == 0) subMask[$urandom % NE] ^= 1'b1;
      flagClr = ($urandom % 6 == 0) ? NS'(1) << ($urandom % NS) : '0;
      regWrEn = ($urandom % 12 == 0);
      regAddr = 3'($urandom % 8);
      regWrData = 8'($urandom);
      if (regAddr == 0 && $urandom % 4 != 0) regWrData[7] = 1'b1;
      ackStb = irqReq ? ($urandom % 3 == 0) : ($urandom % 10 == 0);
      retStb = ($urandom % 7 == 0);
      cyc("R2 R3 R5 R6 R7 R8 R9");
    end
    regWrEn = 0; ackStb = 0; retStb = 0; flagClr = '0;
    cyc("R6");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule